// File: doc/BRIEF.md
# Satellite Ranging Code and Navigation Data Generator

This block is a synthetic transmitter source for receiver testing. Two ten-stage linear feedback shift registers advance once per clock, and each clock is one chip. The ranging chip is the last stage of the first register, combined by XOR with two stages of the second register. The two stages are chosen by a pair of selection inputs, and that pair picks the satellite whose code comes out. A chip counter splits the stream into code periods of 1023 chips. A second counter groups every 20 periods into one navigation data bit, so each data edge falls on the first chip of a code period.

The data bits come from one of two sources. The first is a 16-bit pseudo-random register. The second is a 16-bit pattern that is rotated round. The pattern or seed, the source choice and the two stage selections are all captured while reset is held. After reset they are fixed. The block drives four outputs: the bare code chip, the current data bit, a strobe on the first chip of each code period, and the chip with the data applied.

Top module: `cag_gen`

## Requirements
- R1: While reset is held and on the first cycle after release, the chip index is 0: `epoch_strobe` is 1, `code_chip` is 1, and `data_bit` is bit 15 of the captured data register.
- R2: Stage k of a register is held in bit k-1, and each cycle every stage moves up by one. The new stage 1 of the first register is stage 3 XOR stage 10. The new stage 1 of the second register is the XOR of stages 2, 3, 6, 8, 9 and 10. `code_chip` is stage 10 of the first register XOR the two selected stages of the second register.
- R3: `epoch_strobe` is 1 exactly on chip index 0 of each 1023-chip period, so strobes are 1023 cycles apart.
- R4: On the step from chip 1022 to chip 0, both registers reload all ones, so every code period repeats the same 1023 chips.
- R5: `data_bit` changes only on a chip-0 cycle that starts a new group of 20 code periods, so each bit lasts exactly 20460 cycles.
- R6: `tx_chip` equals `code_chip` XOR `data_bit` on every cycle.
- R7: `tap_sel_a`, `tap_sel_b`, `data_mode` and `data_seed` are captured only while `rst_n` is 0. Changing them after release has no effect on any output.
- R8: A selection value of 1 to 10 names that stage of the second register. A value of 0 or of 11 to 15 selects stage 10. Equal selections cancel, leaving the first register's stage 10 as the chip.
- R9: When `data_mode` is 0, the data register is pseudo-random. On each advance it shifts left and takes bit15 XOR bit13 XOR bit12 XOR bit10 into bit 0. A zero seed is replaced by 1. When `data_mode` is 1, the data register rotates left by one on each advance. In both modes `data_bit` is bit 15.
- R10: With selections 2 and 6, the first ten chips after reset are 1,1,0,0,1,0,0,0,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, one chip per rising edge |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| tap_sel_a | input | 4 | First selected stage of the second register |
| tap_sel_b | input | 4 | Second selected stage of the second register |
| data_mode | input | 1 | 0 = pseudo-random data bits, 1 = rotating pattern |
| data_seed | input | 16 | Seed or pattern for the data register |
| code_chip | output | 1 | Bare ranging code chip |
| data_bit | output | 1 | Current navigation data bit |
| epoch_strobe | output | 1 | High on chip 0 of each code period |
| tx_chip | output | 1 | Code chip with the data bit applied |

## Verification
Once in every 20 code periods, two events fall in the same cycle: the code period wraps and reloads both registers, and the data bit advances. The bench makes this happen by running each configuration past two or more data-bit boundaries. A cycle-exact model then judges every cycle around the boundary. On the shared chip-0 cycle, the strobe must be high, the code chip must restart at 1, and `tx_chip` must already carry the new data bit. Cycles just before and after that chip must still show the old bit and the next code chip.

// File: rtl/cag_pkg.sv
package cag_pkg;
    localparam int STAGES         = 10;
    localparam int CODE_LEN       = 1023;
    localparam int EPOCHS_PER_BIT = 20;
    localparam int DATA_W         = 16;

    // feedback masks: bit k-1 set means stage k feeds the sum
    localparam logic [STAGES-1:0] REF_TAPS  = 10'b10_0000_0100;
    localparam logic [STAGES-1:0] SAT_TAPS  = 10'b11_1010_0110;
    localparam logic [DATA_W-1:0] DATA_TAPS = 16'hB400;

    typedef enum logic {
        DSRC_PRBS    = 1'b0,
        DSRC_PATTERN = 1'b1
    } dsrc_e;
endpackage

// File: rtl/cag_shift_reg.sv
module cag_shift_reg #(
    parameter int              W    = 10,
    parameter logic [W-1:0]    TAPS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    output logic [W-1:0] stages
);
    typedef struct packed {
        logic [W-1:0] sr;
    } sr_state_t;

    sr_state_t   st_d, st_q;
    logic [W-1:0] tapped;
    logic         fb;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_tap
            if (TAPS[gi]) begin : g_on
                assign tapped[gi] = st_q.sr[gi];
            end else begin : g_off
                assign tapped[gi] = 1'b0;
            end
        end
    endgenerate

    assign fb = ^tapped;

    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d.sr = '1;
        end else begin
            st_d.sr = {st_q.sr[W-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages = st_q.sr;
endmodule

// File: rtl/cag_epoch_ctr.sv
module cag_epoch_ctr #(
    parameter int CODE_LEN       = 1023,
    parameter int EPOCHS_PER_BIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic epoch_start,
    output logic epoch_wrap,
    output logic bit_advance
);
    localparam int CW = $clog2(CODE_LEN);
    localparam int EW = $clog2(EPOCHS_PER_BIT);
    localparam logic [CW-1:0] CHIP_LAST = CW'(CODE_LEN - 1);
    localparam logic [EW-1:0] EP_LAST   = EW'(EPOCHS_PER_BIT - 1);

    typedef struct packed {
        logic [CW-1:0] chip;
        logic [EW-1:0] ep;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       at_last_chip;
    logic       at_last_ep;

    assign at_last_chip = (st_q.chip == CHIP_LAST);
    assign at_last_ep   = (st_q.ep == EP_LAST);

    always_comb begin
        st_d = st_q;
        if (at_last_chip) begin
            st_d.chip = '0;
            st_d.ep   = at_last_ep ? '0 : st_q.ep + EW'(1);
        end else begin
            st_d.chip = st_q.chip + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign epoch_start = (st_q.chip == '0);
    assign epoch_wrap  = at_last_chip;
    assign bit_advance = at_last_chip && at_last_ep;
endmodule

// File: rtl/cag_data_src.sv
module cag_data_src
    import cag_pkg::*;
#(
    parameter int                W    = DATA_W,
    parameter logic [W-1:0]      TAPS = DATA_TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_in,
    input  logic [W-1:0] seed_in,
    input  logic         advance,
    output logic         bit_out
);
    typedef struct packed {
        dsrc_e        mode;
        logic [W-1:0] r;
    } dsrc_state_t;

    dsrc_state_t st_d, st_q;
    dsrc_state_t st_rst;
    logic        fb;

    assign fb = ^(st_q.r & TAPS);

    always_comb begin
        st_rst.mode = dsrc_e'(mode_in);
        if (!mode_in && (seed_in == '0)) begin
            st_rst.r = W'(1);
        end else begin
            st_rst.r = seed_in;
        end
    end

    always_comb begin
        st_d = st_q;
        if (advance) begin
            if (st_q.mode == DSRC_PATTERN) begin
                st_d.r = {st_q.r[W-2:0], st_q.r[W-1]};
            end else begin
                st_d.r = {st_q.r[W-2:0], fb};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.r[W-1];
endmodule

// File: rtl/cag_gen.sv
module cag_gen
    import cag_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int SEED_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  tap_sel_a,
    input  logic [SEL_W-1:0]  tap_sel_b,
    input  logic              data_mode,
    input  logic [SEED_W-1:0] data_seed,
    output logic              code_chip,
    output logic              data_bit,
    output logic              epoch_strobe,
    output logic              tx_chip
);
    localparam int IW = $clog2(STAGES);

    typedef struct packed {
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [STAGES-1:0] ref_stages;
    logic [STAGES-1:0] sat_stages;
    logic              epoch_wrap;
    logic              bit_advance;
    logic [IW-1:0]     pos_a;
    logic [IW-1:0]     pos_b;

    function automatic logic [IW-1:0] stage_pos(input logic [SEL_W-1:0] sel);
        logic [IW-1:0] p;
        if (int'(sel) == 0 || int'(sel) > STAGES) begin
            p = IW'(STAGES - 1);
        end else begin
            p = IW'(int'(sel) - 1);
        end
        return p;
    endfunction

    always_comb begin
        cfg_d.sel_a = tap_sel_a;
        cfg_d.sel_b = tap_sel_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_d;
        end
    end

    cag_epoch_ctr #(
        .CODE_LEN       (CODE_LEN),
        .EPOCHS_PER_BIT (EPOCHS_PER_BIT)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .epoch_start (epoch_strobe),
        .epoch_wrap  (epoch_wrap),
        .bit_advance (bit_advance)
    );

    cag_shift_reg #(
        .W    (STAGES),
        .TAPS (REF_TAPS)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (epoch_wrap),
        .stages (ref_stages)
    );

    cag_shift_reg #(
        .W    (STAGES),
        .TAPS (SAT_TAPS)
    ) u_sat (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (epoch_wrap),
        .stages (sat_stages)
    );

    cag_data_src #(
        .W    (SEED_W),
        .TAPS (DATA_TAPS)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (data_mode),
        .seed_in (data_seed),
        .advance (bit_advance),
        .bit_out (data_bit)
    );

    assign pos_a     = stage_pos(cfg_q.sel_a);
    assign pos_b     = stage_pos(cfg_q.sel_b);
    assign code_chip = ref_stages[STAGES-1] ^ sat_stages[pos_a] ^ sat_stages[pos_b];
    assign tx_chip   = code_chip ^ data_bit;
endmodule

// File: rtl/cag_gen_chk.sv
module cag_gen_chk #(
    parameter int CODE_LEN       = 1023,
    parameter int EPOCHS_PER_BIT = 20
) (
    input logic clk,
    input logic rst_n,
    input logic code_chip,
    input logic data_bit,
    input logic epoch_strobe,
    input logic tx_chip
);
    int unsigned chip_cnt;
    int unsigned ep_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_cnt <= 0;
            ep_cnt   <= 0;
        end else if (chip_cnt == CODE_LEN - 1) begin
            chip_cnt <= 0;
            ep_cnt   <= (ep_cnt == EPOCHS_PER_BIT - 1) ? 0 : ep_cnt + 1;
        end else begin
            chip_cnt <= chip_cnt + 1;
        end
    end

    // R3: strobe on exactly the first chip of every period
    p_epoch_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_strobe == (chip_cnt == 0));

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_strobe |=> !epoch_strobe);

    // R4: reload of all ones makes every period start with chip 1
    p_first_chip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_strobe |-> code_chip);

    // R5: data edge only at the start of a 20-period group
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_cnt == 0 && ep_cnt == 0) |-> $stable(data_bit));

    // R6: modulated chip inverts the code exactly when the data bit is 1
    p_tx_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_bit |-> (tx_chip != code_chip));
endmodule

bind cag_gen cag_gen_chk #(
    .CODE_LEN       (cag_pkg::CODE_LEN),
    .EPOCHS_PER_BIT (cag_pkg::EPOCHS_PER_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_chip    (code_chip),
    .data_bit     (data_bit),
    .epoch_strobe (epoch_strobe),
    .tx_chip      (tx_chip)
);

// File: tb/sim_cag_gen.sv
module sim_cag_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tap_sel_a = 4'd2;
    logic [3:0]  tap_sel_b = 4'd6;
    logic        data_mode = 1'b0;
    logic [15:0] data_seed = 16'h1234;
    logic        code_chip, data_bit, epoch_strobe, tx_chip;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cag_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tap_sel_a    (tap_sel_a),
        .tap_sel_b    (tap_sel_b),
        .data_mode    (data_mode),
        .data_seed    (data_seed),
        .code_chip    (code_chip),
        .data_bit     (data_bit),
        .epoch_strobe (epoch_strobe),
        .tx_chip      (tx_chip)
    );

    // model state
    logic [9:0]  m_g1, m_g2;
    logic [15:0] m_dat;
    logic        m_pat;
    int          m_chip, m_ep, m_pa, m_pb;
    logic        first_period [0:1022];

    function automatic int sel_to_pos(input logic [3:0] s);
        if (s >= 4'd1 && s <= 4'd10) return int'(s) - 1;
        return 9;
    endfunction

    function automatic logic [9:0] ref_next(input logic [9:0] r);
        return {r[8:0], r[2] ^ r[9]};
    endfunction

    function automatic logic [9:0] sat_next(input logic [9:0] r);
        return {r[8:0], r[1] ^ r[2] ^ r[5] ^ r[7] ^ r[8] ^ r[9]};
    endfunction

    function automatic logic [15:0] dat_next(input logic [15:0] r, input logic pat);
        if (pat) return {r[14:0], r[15]};
        return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
    endfunction

    function automatic logic m_code();
        return m_g1[9] ^ m_g2[m_pa] ^ m_g2[m_pb];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            if (errors < 30)
                $display("FAIL %s chip=%0d ep=%0d actual=%b expected=%b", req, m_chip, m_ep, act, exp);
        end
    endtask

    task automatic model_step();
        if (m_chip == 1022) begin
            m_g1 = 10'h3FF;
            m_g2 = 10'h3FF;
            m_chip = 0;
            if (m_ep == 19) begin
                m_ep = 0;
                m_dat = dat_next(m_dat, m_pat);
            end else begin
                m_ep++;
            end
        end else begin
            m_g1 = ref_next(m_g1);
            m_g2 = sat_next(m_g2);
            m_chip++;
        end
    endtask

    task automatic run_case(input logic [3:0] a, input logic [3:0] b, input logic mode,
                            input logic [15:0] seed, input int ncyc, input bit prn_check);
        logic [9:0] first10;
        @(negedge clk);
        tap_sel_a = a; tap_sel_b = b; data_mode = mode; data_seed = seed;
        rst_n = 1'b0;
        m_g1 = 10'h3FF; m_g2 = 10'h3FF; m_chip = 0; m_ep = 0;
        m_pa = sel_to_pos(a); m_pb = sel_to_pos(b); m_pat = mode;
        m_dat = (!mode && seed == 16'h0) ? 16'h0001 : seed;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1 strobe in reset", epoch_strobe, 1'b1);
        check("R1 code in reset", code_chip, 1'b1);
        check("R1 data in reset", data_bit, m_dat[15]);
        rst_n = 1'b1;
        first10 = '0;
        for (int n = 0; n < ncyc; n++) begin
            if (n == 0) begin
                check("R1 strobe after release", epoch_strobe, 1'b1);
                check("R1 code after release", code_chip, 1'b1);
            end
            check("R2 code_chip", code_chip, m_code());
            check("R3 epoch_strobe", epoch_strobe, m_chip == 0);
            check("R5/R9 data_bit", data_bit, m_dat[15]);
            check("R6 tx_chip", tx_chip, code_chip ^ data_bit);
            if (n < 1023) first_period[n] = code_chip;
            else if (n < 2046) check("R4 period repeat", code_chip, first_period[n - 1023]);
            if (n < 10) first10[9 - n] = code_chip;
            // R7: configuration inputs wander after release
            tap_sel_a = 4'($urandom);
            tap_sel_b = 4'($urandom);
            data_mode = 1'($urandom);
            data_seed = 16'($urandom);
            model_step();
            @(negedge clk);
        end
        if (prn_check) begin
            checks++;
            if (first10 !== 10'b1100100000) begin
                errors++;
                $display("FAIL R10 first ten chips actual=%b expected=%b", first10, 10'b1100100000);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        // R10, R9 prbs mode, two data boundaries
        run_case(4'd2, 4'd6, 1'b0, 16'($urandom) | 16'h8000, 41000, 1'b1);
        // R9 pattern mode, random selection pair
        run_case(4'(1 + ($urandom % 10)), 4'(1 + ($urandom % 10)), 1'b1, 16'hA5C3, 41000, 1'b0);
        // R8 out-of-range selections
        run_case(4'd0, 4'd13, 1'b0, 16'h0000, 2200, 1'b0);
        // R8 equal selections cancel; R9 zero seed in pattern mode stays zero
        run_case(4'd7, 4'd7, 1'b1, 16'h0000, 2200, 1'b0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule